// File: doc/BRIEF.md
# Halt-Mode Fetch Cycle Sequencer

This block produces the opcode-fetch bus timing of a small 8-bit processor, with particular care for the halted wait. Each machine cycle has four T-states. The first two present the program counter with the fetch, memory-request and read strobes. The last two present a refresh address with the refresh strobe. After the core requests a halt, the sequencer does not stop the bus. It keeps running full fetch-plus-refresh cycles so that dynamic memory stays refreshed. In each of those cycles it throws away the byte returned by memory and hands a no-operation code to the core. An active-low halt-acknowledge output stays low for the whole halt.

The halt ends only on an interrupt. A non-maskable request is caught on its falling edge and held pending. A maskable request is a level that counts only while the core's interrupt-enable flag is set. Both are sampled at the start of T4, and the halt ends on the edge that closes that T4. On that edge the block raises a one-cycle exit pulse and a code that tells the core which acknowledge cycle to run next. The non-maskable request wins when both are present.

Top module: `halt_fetch_seq`

## Requirements
- R1: `tstate` counts 0,1,2,3 (T1..T4) and wraps on every clock. A synchronous active-high `rst` puts the block in T1 with `halt_n`=1, `exit_pulse`=0 and `ack_kind`=0.
- R2: During T1 and T2, `addr` equals `pc_in`, `m1_n`, `mreq_n` and `rd_n` are 0, and `rfsh_n` is 1.
- R3: During T3 and T4, `rfsh_n` and `mreq_n` are 0 and `m1_n` and `rd_n` are 1. The low RFSH_W bits of `addr` carry a refresh count and the upper bits are 0. The count starts at 0 after reset, rises by one at the end of each T4, and wraps modulo 2^RFSH_W.
- R4: `halt_req` is sampled on the edge that ends T4. If it is set, `halt_n` goes to 0 from the next T1. It stays 0 through every following cycle until an exit. Halted cycles keep the full fetch timing with the same `pc_in` address.
- R5: On the edge that ends T2, `opcode` takes a new value and `opcode_valid` is 1 for exactly the T3 cycle. When running, the value is `mem_data`. When halted, it is the no-op code (default 8'h00) and `mem_data` is ignored.
- R6: The interrupt inputs are sampled on the edge that enters T4, and the exit happens on the edge that ends that T4. `halt_n` can only change on an edge entering T1.
- R7: A maskable request (`int_n`=0) causes an exit only if `int_en`=1 at the sample. A request that is released before the sample causes no exit.
- R8: On exit, `halt_n` returns to 1, `exit_pulse` is 1 for one cycle, and `ack_kind` reads 1 for non-maskable or 2 for maskable during that cycle. Otherwise `ack_kind` reads 0.
- R9: When both requests qualify at the same sample, `ack_kind` is 1.
- R10: A falling edge on `nmi_n` is held pending until the exit that acknowledges it, even when the pulse is short or arrives before the halt. Holding `nmi_n` low afterwards does not trigger a second exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_req | input | 1 | Core requests the halted wait |
| pc_in | input | ADDR_W | Program counter address for fetch phases |
| mem_data | input | DATA_W | Byte returned by memory |
| nmi_n | input | 1 | Non-maskable request, falling-edge active |
| int_n | input | 1 | Maskable request, active-low level |
| int_en | input | 1 | Core interrupt-enable flag |
| addr | output | ADDR_W | Address bus |
| m1_n | output | 1 | Fetch cycle strobe, active low |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| halt_n | output | 1 | Halt acknowledge, active low |
| tstate | output | 2 | Current T-state, 0..3 for T1..T4 |
| opcode | output | DATA_W | Opcode handed to the core |
| opcode_valid | output | 1 | Opcode valid, high during T3 |
| exit_pulse | output | 1 | One-cycle halt-exit pulse |
| ack_kind | output | 2 | 0 none, 1 non-maskable, 2 maskable |

## Verification
Bus strobes and the address follow the T-state that a clock edge has just entered, so the bench reads them one quarter period after that edge. The opcode is due in the T3 that follows its capture edge. When a request is applied at the start of a halted T1, the exit pulse and its code are due exactly four edges later, in the next T1. The bench therefore applies every interrupt stimulus at T1. It checks that `halt_n` is still low at T4, three edges later, and checks the exit outputs after the fourth edge. A stimulus that must not cause an exit is checked at the same point.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

  typedef enum logic [1:0] {
    TS_T1 = 2'd0,
    TS_T2 = 2'd1,
    TS_T3 = 2'd2,
    TS_T4 = 2'd3
  } tstate_e;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_NMI  = 2'd1,
    ACK_INT  = 2'd2
  } ack_e;

  typedef struct packed {
    logic m1_n;
    logic mreq_n;
    logic rd_n;
    logic rfsh_n;
  } strobe_s;

  function automatic strobe_s strobes_for(tstate_e ts);
    strobe_s s;
    if (ts == TS_T1 || ts == TS_T2) begin
      s.m1_n   = 1'b0;
      s.mreq_n = 1'b0;
      s.rd_n   = 1'b0;
      s.rfsh_n = 1'b1;
    end else begin
      s.m1_n   = 1'b1;
      s.mreq_n = 1'b0;
      s.rd_n   = 1'b1;
      s.rfsh_n = 1'b0;
    end
    return s;
  endfunction

  function automatic logic is_fetch_phase(tstate_e ts);
    return (ts == TS_T1) || (ts == TS_T2);
  endfunction

endpackage

// File: rtl/hfs_tstate_gen.sv
module hfs_tstate_gen
  import hfs_pkg::*;
#(
  parameter int RFSH_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  output tstate_e           t_cur,
  output tstate_e           t_load,
  output logic [RFSH_W-1:0] rfsh_cnt
);

  logic [1:0] t_inc;

  assign t_inc  = t_cur + 2'd1;
  assign t_load = rst ? TS_T1 : tstate_e'(t_inc);

  always_ff @(posedge clk) begin
    t_cur <= t_load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rfsh_cnt <= '0;
    end else if (t_cur == TS_T4) begin
      rfsh_cnt <= rfsh_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/hfs_irq_sample.sv
module hfs_irq_sample (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic int_n,
  input  logic int_en,
  input  logic sample_en,
  input  logic consume_nmi,
  output logic req_nmi,
  output logic req_int
);

  logic nmi_q;
  logic nmi_fall;
  logic nmi_pend;

  assign nmi_fall = nmi_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b1;
    end else begin
      nmi_q <= nmi_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend <= 1'b0;
    end else if (nmi_fall) begin
      nmi_pend <= 1'b1;
    end else if (consume_nmi) begin
      nmi_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_nmi <= 1'b0;
      req_int <= 1'b0;
    end else if (sample_en) begin
      req_nmi <= nmi_pend | nmi_fall;
      req_int <= ~int_n & int_en;
    end
  end

endmodule

// File: rtl/hfs_bus_drive.sv
module hfs_bus_drive
  import hfs_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter int              RFSH_W   = 7,
  parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  tstate_e           t_cur,
  input  tstate_e           t_load,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [RFSH_W-1:0] rfsh_cnt,
  input  logic              halted,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] addr,
  output strobe_s           strb,
  output logic [DATA_W-1:0] opcode,
  output logic              opcode_valid
);

  localparam int PAD_W = ADDR_W - RFSH_W;

  logic [ADDR_W-1:0] rfsh_addr;
  logic              capture;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rfsh_addr = {{PAD_W{1'b0}}, rfsh_cnt};
    end else begin : g_nopad
      assign rfsh_addr = rfsh_cnt[ADDR_W-1:0];
    end
  endgenerate

  assign capture = ~rst && (t_cur == TS_T2);

  always_ff @(posedge clk) begin
    strb <= strobes_for(t_load);
    addr <= is_fetch_phase(t_load) ? pc_in : rfsh_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode       <= NOP_CODE;
      opcode_valid <= 1'b0;
    end else begin
      opcode_valid <= capture;
      if (capture) begin
        opcode <= halted ? NOP_CODE : mem_data;
      end
    end
  end

endmodule

// File: rtl/halt_fetch_seq.sv
module halt_fetch_seq
  import hfs_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                RFSH_W   = 7,
  parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              nmi_n,
  input  logic              int_n,
  input  logic              int_en,
  output logic [ADDR_W-1:0] addr,
  output logic              m1_n,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              rfsh_n,
  output logic              halt_n,
  output logic [1:0]        tstate,
  output logic [DATA_W-1:0] opcode,
  output logic              opcode_valid,
  output logic              exit_pulse,
  output logic [1:0]        ack_kind
);

  tstate_e           t_cur;
  tstate_e           t_load;
  logic [RFSH_W-1:0] rfsh_cnt;
  logic              req_nmi;
  logic              req_int;
  logic              halted;
  logic              wake;
  logic              consume_nmi;
  ack_e              ack_q;
  strobe_s           strb;

  hfs_tstate_gen #(.RFSH_W(RFSH_W)) u_tgen (
    .clk      (clk),
    .rst      (rst),
    .t_cur    (t_cur),
    .t_load   (t_load),
    .rfsh_cnt (rfsh_cnt)
  );

  hfs_irq_sample u_irq (
    .clk         (clk),
    .rst         (rst),
    .nmi_n       (nmi_n),
    .int_n       (int_n),
    .int_en      (int_en),
    .sample_en   (t_cur == TS_T3),
    .consume_nmi (consume_nmi),
    .req_nmi     (req_nmi),
    .req_int     (req_int)
  );

  hfs_bus_drive #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RFSH_W   (RFSH_W),
    .NOP_CODE (NOP_CODE)
  ) u_bus (
    .clk          (clk),
    .rst          (rst),
    .t_cur        (t_cur),
    .t_load       (t_load),
    .pc_in        (pc_in),
    .rfsh_cnt     (rfsh_cnt),
    .halted       (halted),
    .mem_data     (mem_data),
    .addr         (addr),
    .strb         (strb),
    .opcode       (opcode),
    .opcode_valid (opcode_valid)
  );

  assign wake        = halted && (req_nmi || req_int);
  assign consume_nmi = (t_cur == TS_T4) && halted && req_nmi;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted     <= 1'b0;
      exit_pulse <= 1'b0;
      ack_q      <= ACK_NONE;
    end else begin
      exit_pulse <= 1'b0;
      ack_q      <= ACK_NONE;
      if (t_cur == TS_T4) begin
        if (wake) begin
          halted     <= 1'b0;
          exit_pulse <= 1'b1;
          ack_q      <= req_nmi ? ACK_NMI : ACK_INT;
        end else if (!halted && halt_req) begin
          halted <= 1'b1;
        end
      end
    end
  end

  assign m1_n     = strb.m1_n;
  assign mreq_n   = strb.mreq_n;
  assign rd_n     = strb.rd_n;
  assign rfsh_n   = strb.rfsh_n;
  assign halt_n   = ~halted;
  assign tstate   = t_cur;
  assign ack_kind = ack_q;

endmodule

// File: rtl/hfs_checker.sv
module hfs_checker #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        tstate,
  input logic              m1_n,
  input logic              mreq_n,
  input logic              rd_n,
  input logic              rfsh_n,
  input logic              halt_n,
  input logic [DATA_W-1:0] opcode,
  input logic              opcode_valid,
  input logic              exit_pulse,
  input logic [1:0]        ack_kind,
  input logic              int_n,
  input logic              int_en
);

  p_tstate_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tstate == 2'($past(tstate) + 2'd1));

  p_fetch_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    (tstate < 2'd2) |-> (!m1_n && !mreq_n && !rd_n && rfsh_n));

  p_refresh_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    (tstate >= 2'd2) |-> (!rfsh_n && !mreq_n && m1_n && rd_n));

  p_halt_edge_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(halt_n) |-> tstate == 2'd0);

  p_nop_when_halted_r5: assert property (@(posedge clk) disable iff (rst)
    (opcode_valid && !halt_n) |-> (opcode == NOP_CODE && tstate == 2'd2));

  p_rise_needs_exit_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_n) |-> (exit_pulse && ack_kind != 2'd0));

  p_exit_single_r8: assert property (@(posedge clk) disable iff (rst)
    exit_pulse |=> !exit_pulse);

  p_ack_only_on_exit_r8: assert property (@(posedge clk) disable iff (rst)
    !exit_pulse |-> ack_kind == 2'd0);

  p_maskable_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (exit_pulse && ack_kind == 2'd2) |-> ($past(int_en, 2) && !$past(int_n, 2)));

endmodule

bind halt_fetch_seq hfs_checker #(
  .DATA_W   (DATA_W),
  .NOP_CODE (NOP_CODE)
) u_hfs_checker (
  .clk          (clk),
  .rst          (rst),
  .tstate       (tstate),
  .m1_n         (m1_n),
  .mreq_n       (mreq_n),
  .rd_n         (rd_n),
  .rfsh_n       (rfsh_n),
  .halt_n       (halt_n),
  .opcode       (opcode),
  .opcode_valid (opcode_valid),
  .exit_pulse   (exit_pulse),
  .ack_kind     (ack_kind),
  .int_n        (int_n),
  .int_en       (int_en)
);

// File: tb/halt_fetch_seq_test.sv
module halt_fetch_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int RFSH_W = 7;
  localparam logic [ADDR_W-1:0] PC_VAL = 16'h1234;
  localparam logic [DATA_W-1:0] MEM_VAL = 8'hC3;

  // {int_en, int_low, nmi_pulse, exit_expected, ack_expected[1:0]}
  localparam logic [5:0] VEC [0:5] = '{
    6'b110110,
    6'b010000,
    6'b001101,
    6'b111101,
    6'b011101,
    6'b100000
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              halt_req = 1'b0;
  logic [ADDR_W-1:0] pc_in = PC_VAL;
  logic [DATA_W-1:0] mem_data = MEM_VAL;
  logic              nmi_n = 1'b1;
  logic              int_n = 1'b1;
  logic              int_en = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic              m1_n, mreq_n, rd_n, rfsh_n, halt_n;
  logic [1:0]        tstate;
  logic [DATA_W-1:0] opcode;
  logic              opcode_valid, exit_pulse;
  logic [1:0]        ack_kind;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_fetch_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RFSH_W(RFSH_W)) uut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .pc_in(pc_in), .mem_data(mem_data),
    .nmi_n(nmi_n), .int_n(int_n), .int_en(int_en), .addr(addr), .m1_n(m1_n),
    .mreq_n(mreq_n), .rd_n(rd_n), .rfsh_n(rfsh_n), .halt_n(halt_n), .tstate(tstate),
    .opcode(opcode), .opcode_valid(opcode_valid), .exit_pulse(exit_pulse),
    .ack_kind(ack_kind)
  );

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; halt_req = 1'b0; nmi_n = 1'b1; int_n = 1'b1; int_en = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic enter_halt();
    halt_req = 1'b1;
    repeat (4) step();
    halt_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/4);
    do_reset();

    // R1 reset state, R2 T1 strobes
    check("R1 tstate after reset", tstate, 0);
    check("R1 halt_n after reset", halt_n, 1);
    check("R1 exit_pulse after reset", exit_pulse, 0);
    check("R1 ack_kind after reset", ack_kind, 0);
    check("R2 T1 strobes m1/mreq/rd/rfsh", {m1_n, mreq_n, rd_n, rfsh_n}, 4'b0001);
    check("R2 T1 addr", addr, PC_VAL);

    step();
    check("R1 tstate T2", tstate, 1);
    check("R2 T2 m1_n", m1_n, 0);
    step();
    check("R3 T3 strobes m1/mreq/rd/rfsh", {m1_n, mreq_n, rd_n, rfsh_n}, 4'b1010);
    check("R3 refresh addr cycle 0", addr, 0);
    check("R5 running opcode", opcode, MEM_VAL);
    check("R5 opcode_valid in T3", opcode_valid, 1);
    step();
    check("R5 opcode_valid single cycle", opcode_valid, 0);
    check("R3 T4 rfsh_n", rfsh_n, 0);
    step(); step(); step();
    check("R3 refresh addr cycle 1", addr, 1);
    for (int c = 2; c < 130; c++) begin
      repeat (4) step();
      check("R3 refresh count wrap", addr, c % 128);
    end

    // R4 halt entry and halted fetch cycles
    do_reset();
    enter_halt();
    check("R4 halt_n low after entry", halt_n, 0);
    check("R4 halted T1 addr", addr, PC_VAL);
    step();
    check("R4 halted T2 fetch strobes", {m1_n, mreq_n, rd_n}, 3'b000);
    step();
    check("R5 halted opcode is NOP", opcode, 0);
    check("R5 halted opcode_valid", opcode_valid, 1);
    check("R3 halted refresh strobe", rfsh_n, 0);
    step(); step();
    check("R4 halt_n held next cycle", halt_n, 0);
    check("R4 same address next cycle", addr, PC_VAL);

    // R7 R8 R9 R10 table of interrupt cases
    for (int v = 0; v < 6; v++) begin
      do_reset();
      enter_halt();
      int_en = VEC[v][5];
      int_n  = ~VEC[v][4];
      nmi_n  = ~VEC[v][3];
      step();
      nmi_n = 1'b1;
      step(); step();
      check($sformatf("R6 vec%0d still halted in T4", v), halt_n, 0);
      check($sformatf("R6 vec%0d no early exit", v), exit_pulse, 0);
      step();
      check($sformatf("R7 vec%0d exit_pulse", v), exit_pulse, VEC[v][2]);
      check($sformatf("R8 vec%0d halt_n", v), halt_n, VEC[v][2]);
      check($sformatf("R9 vec%0d ack_kind", v), ack_kind, VEC[v][1:0]);
      step();
      check($sformatf("R8 vec%0d pulse ends", v), {exit_pulse, ack_kind}, 0);
      int_n = 1'b1;
    end

    // R7 request dropped before the T4 sample
    do_reset();
    enter_halt();
    int_en = 1'b1; int_n = 1'b0;
    step(); step();
    int_n = 1'b1;
    step(); step();
    check("R7 released request no exit", halt_n, 0);
    check("R7 released request ack", ack_kind, 0);

    // R10 held-low nmi triggers once
    do_reset();
    enter_halt();
    nmi_n = 1'b0;
    repeat (4) step();
    check("R10 held nmi first exit", ack_kind, 1);
    enter_halt();
    check("R10 re-halted", halt_n, 0);
    repeat (4) step();
    check("R10 held nmi no retrigger", halt_n, 0);
    check("R10 held nmi no pulse", exit_pulse, 0);
    nmi_n = 1'b1;

    // R10 nmi edge before halt entry stays pending
    do_reset();
    nmi_n = 1'b0;
    step();
    nmi_n = 1'b1;
    halt_req = 1'b1;
    repeat (3) step();
    halt_req = 1'b0;
    check("R10 halted after early nmi", halt_n, 0);
    repeat (4) step();
    check("R10 pending nmi exit", exit_pulse, 1);
    check("R10 pending nmi ack", ack_kind, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule